// File: doc/BRIEF.md
# NAND Flash Bus Bridge with ECC

This block sits between a processor register port and a raw 8-bit NAND flash device. A control register drives the flash pins directly: two chip selects, the command latch, the address latch and the write protect. The flash ready/busy pin is read back through the same register. Software issues commands, addresses and data by setting the latch pins and then moving bytes through a single data register. Each data register access produces one flash write strobe or read strobe per byte.

Every byte that moves through the data register, in either direction, also passes through a running ECC accumulator. This is a Hamming-style scheme over 256-byte blocks. It keeps 6 column-parity bits, two 8-bit line-parity words indexed by the low byte of a byte counter, and the counter itself. Software reads the line parity through two registers that interleave the two words bit by bit, and reads the column parity and the low byte of the counter through two more. A write to a clear register zeroes the accumulator. A 32-bit read of the data register fetches two flash bytes in one request. Each request is acknowledged by a single-cycle `ack`, which is also when `rdata` is valid.

Top module: `nandb_bridge`

## Requirements
- R1: After reset, `ack`, both strobes and all five control pins are 0, and the column parity, both line-parity registers and the counter read 0.
- R2: A write to offset 0x18 stores bits 7:0 with bit 5 forced to 0. From the next cycle the pins follow the stored bits: `fl_ce0` is bit 0, `fl_cle` bit 1, `fl_ale` bit 2, `fl_wp` bit 3 and `fl_ce1` bit 4. The pins stay unchanged until the next such write.
- R3: A read of offset 0x18 returns the stored control byte, with bit 5 replaced by the level of `fl_rdy`.
- R4: A write to offset 0x14 gives exactly one cycle of `fl_wr_stb`, with `fl_dq_out` equal to `req_wdata[7:0]`. The byte enters the ECC, and `ack` follows in the next cycle. The two strobes are never high together.
- R5: A byte read of offset 0x14 gives exactly one cycle of `fl_rd_stb` and returns the sampled flash byte in `rdata[7:0]`, with all other bits 0. The byte enters the ECC.
- R6: A wide read (`req_wide`=1) of offset 0x14 gives two consecutive read strobes. The first byte is returned in `rdata[7:0]` and the second in `rdata[23:16]`, with bits 15:8 and 31:24 equal to 0. Both bytes enter the ECC in order.
- R7: A read of offset 0x08 returns the column parity in bits 5:0, with bits 7:6 equal to 0. Each processed byte b toggles the following bits, each by the XOR of the listed bits of b: bit 0 by b bits {0,2,4,6}, bit 1 by {1,3,5,7}, bit 2 by {0,1,4,5}, bit 3 by {2,3,6,7}, bit 4 by {0..3} and bit 5 by {4..7}.
- R8: For each processed byte with an odd number of ones, line word A is XORed with the bitwise inverse of the counter's low byte and line word B is XORed with that low byte. The counter value used is the one before the byte. The counter then advances by one for every byte, and a read of offset 0x0C returns its low 8 bits.
- R9: A read of offset 0x00 returns line word A bits 3:0 in even bit positions 0, 2, 4, 6 and line word B bits 3:0 in odd positions 1, 3, 5, 7. A read of offset 0x04 does the same with bits 7:4 of both words.
- R10: A write to offset 0x10 zeroes the column parity, both line words and the counter, whatever data is written.
- R11: A read of any other offset returns 0. A write to any offset other than 0x10, 0x14 and 0x18 changes nothing: no strobe, no ECC change, no control change.
- R12: Every request accepted while idle gets exactly one `ack` pulse, one cycle long.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request pulse, taken when the block is idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 32-bit read of the data register |
| req_addr | input | ADDR_W (6) | Byte offset in the register window |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse, `rdata` valid |
| rdata | output | 32 | Read data |
| fl_ce0 | output | 1 | Chip select 0 (control bit 0) |
| fl_ce1 | output | 1 | Chip select 1 (control bit 4) |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_wp | output | 1 | Write protect |
| fl_rdy | input | 1 | Flash ready (1) / busy (0) |
| fl_dq_out | output | 8 | Byte driven toward the flash |
| fl_dq_in | input | 8 | Byte returned by the flash, sampled at the end of a read strobe |
| fl_wr_stb | output | 1 | One-cycle write strobe |
| fl_rd_stb | output | 1 | One-cycle read strobe |

## Verification
The bound assertions watch the local cycle rules on every cycle. They check that the strobes are exclusive and only occur during a transfer, that `ack` is one cycle wide and follows each write strobe, and that the control pins load on a control write and hold otherwise. They also check that the counter steps once per digested byte and stands still otherwise, and that a clear zeroes the whole accumulator. The arithmetic content of the ECC can only be shown by the bench scenarios, which compare the parity readback against an independently computed expectation after known byte streams. The same goes for the bit interleaving, the byte placement of a wide read, the ready-bit substitution and the absence of effects from undefined offsets.

// File: rtl/nandb_pkg.sv
package nandb_pkg;

  localparam int unsigned OFS_W = 6;

  // register offsets inside the window
  localparam logic [OFS_W-1:0] OFS_LPLO = 6'h00;
  localparam logic [OFS_W-1:0] OFS_LPHI = 6'h04;
  localparam logic [OFS_W-1:0] OFS_CPAR = 6'h08;
  localparam logic [OFS_W-1:0] OFS_CNT  = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_CLR  = 6'h10;
  localparam logic [OFS_W-1:0] OFS_DATA = 6'h14;
  localparam logic [OFS_W-1:0] OFS_CTL  = 6'h18;

  // control register bit positions
  localparam int unsigned CB_CE0 = 0;
  localparam int unsigned CB_CLE = 1;
  localparam int unsigned CB_ALE = 2;
  localparam int unsigned CB_WP  = 3;
  localparam int unsigned CB_CE1 = 4;
  localparam int unsigned CB_RDY = 5;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CP_W   = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER1 = 2'd1,
    ST_XFER2 = 2'd2,
    ST_RESP  = 2'd3
  } seq_st_t;

  // column parity contribution of one byte
  function automatic logic [CP_W-1:0] col_fold(input logic [BYTE_W-1:0] b);
    logic [CP_W-1:0] r;
    r[0] = ^(b & 8'h55);
    r[1] = ^(b & 8'hAA);
    r[2] = ^(b & 8'h33);
    r[3] = ^(b & 8'hCC);
    r[4] = ^(b & 8'h0F);
    r[5] = ^(b & 8'hF0);
    return r;
  endfunction

  // even positions from ev, odd positions from od
  function automatic logic [BYTE_W-1:0] weave(input logic [3:0] ev, input logic [3:0] od);
    logic [BYTE_W-1:0] r;
    for (int k = 0; k < 4; k++) begin
      r[2*k]   = ev[k];
      r[2*k+1] = od[k];
    end
    return r;
  endfunction

endpackage

// File: rtl/nandb_ecc.sv
module nandb_ecc
  import nandb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              dig_en,
  input  logic [BYTE_W-1:0] dig_byte,
  output logic [CP_W-1:0]   cp,
  output logic [BYTE_W-1:0] lp_a,
  output logic [BYTE_W-1:0] lp_b,
  output logic [CNT_W-1:0]  cnt
);

  logic [CP_W-1:0]   cp_n;
  logic [BYTE_W-1:0] lp_a_n, lp_b_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              upd;

  assign upd = clr | dig_en;

  always_comb begin
    cp_n   = cp;
    lp_a_n = lp_a;
    lp_b_n = lp_b;
    cnt_n  = cnt;
    if (clr) begin
      cp_n   = '0;
      lp_a_n = '0;
      lp_b_n = '0;
      cnt_n  = '0;
    end else if (dig_en) begin
      cp_n = cp ^ col_fold(dig_byte);
      if (^dig_byte) begin
        lp_a_n = lp_a ^ ~cnt[BYTE_W-1:0];
        lp_b_n = lp_b ^ cnt[BYTE_W-1:0];
      end
      cnt_n = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp   <= '0;
      lp_a <= '0;
      lp_b <= '0;
      cnt  <= '0;
    end else if (upd) begin
      cp   <= cp_n;
      lp_a <= lp_a_n;
      lp_b <= lp_b_n;
      cnt  <= cnt_n;
    end
  end

endmodule

// File: rtl/nandb_ctl.sv
module nandb_ctl
  import nandb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctl_q,
  output logic              pin_ce0,
  output logic              pin_ce1,
  output logic              pin_cle,
  output logic              pin_ale,
  output logic              pin_wp
);

  localparam logic [BYTE_W-1:0] RDY_MASK = BYTE_W'(1) << CB_RDY;

  logic [BYTE_W-1:0] ctl_n;

  always_comb begin
    ctl_n = ctl_q;
    if (wr_en) ctl_n = wdata & ~RDY_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_n;
  end

  assign pin_ce0 = ctl_q[CB_CE0];
  assign pin_ce1 = ctl_q[CB_CE1];
  assign pin_cle = ctl_q[CB_CLE];
  assign pin_ale = ctl_q[CB_ALE];
  assign pin_wp  = ctl_q[CB_WP];

endmodule

// File: rtl/nandb_seq.sv
module nandb_seq
  import nandb_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic [BYTE_W-1:0] fl_dq_in,
  input  logic              fl_rdy,
  input  logic [BYTE_W-1:0] ctl_q,
  input  logic [CP_W-1:0]   ecc_cp,
  input  logic [BYTE_W-1:0] ecc_lp_a,
  input  logic [BYTE_W-1:0] ecc_lp_b,
  input  logic [BYTE_W-1:0] ecc_cnt8,
  output logic              ack,
  output logic [31:0]       rdata,
  output logic              fl_rd_stb,
  output logic              fl_wr_stb,
  output logic [BYTE_W-1:0] fl_dq_out,
  output logic              ctl_we,
  output logic              ecc_clr,
  output logic              dig_en,
  output logic [BYTE_W-1:0] dig_byte,
  output logic              busy
);

  localparam logic [ADDR_W-1:0] A_LPLO = ADDR_W'(OFS_LPLO);
  localparam logic [ADDR_W-1:0] A_LPHI = ADDR_W'(OFS_LPHI);
  localparam logic [ADDR_W-1:0] A_CPAR = ADDR_W'(OFS_CPAR);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);

  seq_st_t           st, st_n;
  logic              op_wr, op_wr_n;
  logic              op_wide, op_wide_n;
  logic [BYTE_W-1:0] wbyte, wbyte_n;
  logic [31:0]       rdata_n;
  logic              accept;
  logic [BYTE_W-1:0] reg_sel;

  assign accept = (st == ST_IDLE) && req;

  // register readback selection
  always_comb begin
    unique case (req_addr)
      A_LPLO:  reg_sel = weave(ecc_lp_a[3:0], ecc_lp_b[3:0]);
      A_LPHI:  reg_sel = weave(ecc_lp_a[7:4], ecc_lp_b[7:4]);
      A_CPAR:  reg_sel = {{(BYTE_W-CP_W){1'b0}}, ecc_cp};
      A_CNT:   reg_sel = ecc_cnt8;
      A_CTL:   reg_sel = ctl_q | (BYTE_W'(fl_rdy) << CB_RDY);
      default: reg_sel = '0;
    endcase
  end

  // next state
  always_comb begin
    st_n      = st;
    op_wr_n   = op_wr;
    op_wide_n = op_wide;
    wbyte_n   = wbyte;
    rdata_n   = rdata;
    fl_rd_stb = 1'b0;
    fl_wr_stb = 1'b0;
    dig_en    = 1'b0;
    dig_byte  = fl_dq_in;
    ack       = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req) begin
          rdata_n = '0;
          if (req_addr == A_DATA) begin
            op_wr_n   = req_wr;
            op_wide_n = req_wide & ~req_wr;
            wbyte_n   = req_wdata;
            st_n      = ST_XFER1;
          end else begin
            if (!req_wr) rdata_n = {24'h0, reg_sel};
            st_n = ST_RESP;
          end
        end
      end
      ST_XFER1: begin
        dig_en = 1'b1;
        if (op_wr) begin
          fl_wr_stb = 1'b1;
          dig_byte  = wbyte;
        end else begin
          fl_rd_stb    = 1'b1;
          rdata_n[7:0] = fl_dq_in;
        end
        st_n = op_wide ? ST_XFER2 : ST_RESP;
      end
      ST_XFER2: begin
        dig_en         = 1'b1;
        fl_rd_stb      = 1'b1;
        rdata_n[23:16] = fl_dq_in;
        st_n           = ST_RESP;
      end
      ST_RESP: begin
        ack  = 1'b1;
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign ctl_we    = accept && req_wr && (req_addr == A_CTL);
  assign ecc_clr   = accept && req_wr && (req_addr == A_CLR);
  assign fl_dq_out = wbyte;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op_wr   <= 1'b0;
      op_wide <= 1'b0;
      wbyte   <= '0;
      rdata   <= '0;
    end else begin
      st      <= st_n;
      op_wr   <= op_wr_n;
      op_wide <= op_wide_n;
      wbyte   <= wbyte_n;
      rdata   <= rdata_n;
    end
  end

endmodule

// File: rtl/nandb_bridge.sv
module nandb_bridge
  import nandb_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              ack,
  output logic [31:0]       rdata,
  output logic              fl_ce0,
  output logic              fl_ce1,
  output logic              fl_cle,
  output logic              fl_ale,
  output logic              fl_wp,
  input  logic              fl_rdy,
  output logic [7:0]        fl_dq_out,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_wr_stb,
  output logic              fl_rd_stb
);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic [BYTE_W-1:0] ctl_q;
  logic              ctl_we;
  logic              ecc_clr;
  logic              dig_en;
  logic [BYTE_W-1:0] dig_byte;
  logic [CP_W-1:0]   ecc_cp;
  logic [BYTE_W-1:0] ecc_lp_a, ecc_lp_b;
  logic [CNT_W-1:0]  ecc_cnt;
  logic              busy;

  nandb_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (ctl_we),
    .wdata   (req_wdata),
    .ctl_q   (ctl_q),
    .pin_ce0 (fl_ce0),
    .pin_ce1 (fl_ce1),
    .pin_cle (fl_cle),
    .pin_ale (fl_ale),
    .pin_wp  (fl_wp)
  );

  nandb_ecc #(.CNT_W(CNT_W)) u_ecc (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clr      (ecc_clr),
    .dig_en   (dig_en),
    .dig_byte (dig_byte),
    .cp       (ecc_cp),
    .lp_a     (ecc_lp_a),
    .lp_b     (ecc_lp_b),
    .cnt      (ecc_cnt)
  );

  nandb_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .req       (req),
    .req_wr    (req_wr),
    .req_wide  (req_wide),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .fl_dq_in  (fl_dq_in),
    .fl_rdy    (fl_rdy),
    .ctl_q     (ctl_q),
    .ecc_cp    (ecc_cp),
    .ecc_lp_a  (ecc_lp_a),
    .ecc_lp_b  (ecc_lp_b),
    .ecc_cnt8  (ecc_cnt[BYTE_W-1:0]),
    .ack       (ack),
    .rdata     (rdata),
    .fl_rd_stb (fl_rd_stb),
    .fl_wr_stb (fl_wr_stb),
    .fl_dq_out (fl_dq_out),
    .ctl_we    (ctl_we),
    .ecc_clr   (ecc_clr),
    .dig_en    (dig_en),
    .dig_byte  (dig_byte),
    .busy      (busy)
  );

endmodule

// File: rtl/nandb_bridge_chk.sv
module nandb_bridge_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             ack,
  input logic             busy,
  input logic             fl_rd_stb,
  input logic             fl_wr_stb,
  input logic [4:0]       pins,
  input logic [4:0]       wlow,
  input logic             ctl_we,
  input logic             ecc_clr,
  input logic             dig_en,
  input logic [CNT_W-1:0] ecc_cnt,
  input logic [5:0]       ecc_cp,
  input logic [7:0]       ecc_lp_a,
  input logic [7:0]       ecc_lp_b
);

  p_excl_strobe_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(fl_rd_stb && fl_wr_stb));

  p_wr_then_ack_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    fl_wr_stb |=> ack);

  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    ack |=> !ack);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy |-> (!fl_rd_stb && !fl_wr_stb));

  p_ctl_load_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctl_we |=> pins == $past(wlow));

  p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ctl_we |=> $stable(pins));

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    dig_en |=> ecc_cnt == $past(ecc_cnt) + CNT_W'(1));

  p_ecc_hold_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!dig_en && !ecc_clr) |=> $stable(ecc_cnt) && $stable(ecc_cp));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    ecc_clr |=> (ecc_cnt == '0) && (ecc_cp == '0) && (ecc_lp_a == '0) && (ecc_lp_b == '0));

endmodule

bind nandb_bridge nandb_bridge_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .ack       (ack),
  .busy      (busy),
  .fl_rd_stb (fl_rd_stb),
  .fl_wr_stb (fl_wr_stb),
  .pins      ({fl_ce1, fl_wp, fl_ale, fl_cle, fl_ce0}),
  .wlow      (req_wdata[4:0]),
  .ctl_we    (ctl_we),
  .ecc_clr   (ecc_clr),
  .dig_en    (dig_en),
  .ecc_cnt   (ecc_cnt),
  .ecc_cp    (ecc_cp),
  .ecc_lp_a  (ecc_lp_a),
  .ecc_lp_b  (ecc_lp_b)
);

// File: tb/test_nandb_bridge.sv
module test_nandb_bridge;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_wr = 1'b0, req_wide = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ack;
  logic [31:0] rdata;
  logic        fl_ce0, fl_ce1, fl_cle, fl_ale, fl_wp;
  logic        fl_rdy = 1'b0;
  logic [7:0]  fl_dq_out, fl_dq_in;
  logic        fl_wr_stb, fl_rd_stb;

  always #(CLK_P/2) clk = ~clk;

  nandb_bridge i_nandb_bridge (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .fl_ce0(fl_ce0), .fl_ce1(fl_ce1), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_wp(fl_wp),
    .fl_rdy(fl_rdy), .fl_dq_out(fl_dq_out), .fl_dq_in(fl_dq_in),
    .fl_wr_stb(fl_wr_stb), .fl_rd_stb(fl_rd_stb)
  );

  // flash model: byte stream, pointer advances after each read strobe
  logic [7:0] fmem [16];
  logic [3:0] fptr = '0;
  logic       pend = 1'b0;
  int         wr_seen = 0, rd_seen = 0, ack_long = 0;
  logic [7:0] wr_last = '0;
  logic       ack_prev = 1'b0;
  assign fl_dq_in = fmem[fptr];

  always @(negedge clk) begin
    if (pend) fptr = fptr + 4'd1;
    pend = fl_rd_stb;
    if (fl_rd_stb) rd_seen++;
    if (fl_wr_stb) begin wr_seen++; wr_last = fl_dq_out; end
    if (ack && ack_prev) ack_long++;
    ack_prev = ack;
  end

  int total = 0, bad = 0;
  logic finished = 1'b0;

  // expected ECC state
  logic [5:0] e_cp = '0;
  logic [7:0] e_la = '0, e_lb = '0;
  int         e_cnt = 0;
  int         mptr = 0;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic model_digest(input logic [7:0] b);
    logic par;
    par = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) begin
        par = ~par;
        if (i % 2 == 0) e_cp[0] = ~e_cp[0]; else e_cp[1] = ~e_cp[1];
        if (i % 4 < 2)  e_cp[2] = ~e_cp[2]; else e_cp[3] = ~e_cp[3];
        if (i < 4)      e_cp[4] = ~e_cp[4]; else e_cp[5] = ~e_cp[5];
      end
    end
    if (par) begin
      e_la = e_la ^ ~8'(e_cnt);
      e_lb = e_lb ^ 8'(e_cnt);
    end
    e_cnt++;
  endtask

  task automatic model_clear();
    e_cp = '0; e_la = '0; e_lb = '0; e_cnt = 0;
  endtask

  function automatic logic [7:0] mix(input logic [3:0] ev, input logic [3:0] od);
    logic [7:0] r;
    for (int k = 0; k < 4; k++) begin r[2*k] = ev[k]; r[2*k+1] = od[k]; end
    return r;
  endfunction

  task automatic access(input logic wr, input logic wide, input logic [5:0] a,
                        input logic [7:0] d, output logic [31:0] q);
    int n;
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_wide = wide; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    n = 0;
    while (!ack && n < 20) begin @(negedge clk); n++; end
    if (!ack) begin
      total++; bad++;
      $display("FAIL R12 actual=no-ack expected=ack");
    end
    q = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] q;
    check("R1 ack", 32'(ack), 0);
    check("R1 pins", {27'd0, fl_ce1, fl_wp, fl_ale, fl_cle, fl_ce0}, 0);
    check("R1 strobes", {30'd0, fl_wr_stb, fl_rd_stb}, 0);
    access(1'b0, 1'b0, 6'h00, 8'h00, q); check("R1 lplo", q, 0);
    access(1'b0, 1'b0, 6'h04, 8'h00, q); check("R1 lphi", q, 0);
    access(1'b0, 1'b0, 6'h08, 8'h00, q); check("R1 cpar", q, 0);
    access(1'b0, 1'b0, 6'h0C, 8'h00, q); check("R1 cnt", q, 0);
  endtask

  task automatic t_control();
    logic [31:0] q;
    access(1'b1, 1'b0, 6'h18, 8'hFF, q);
    @(negedge clk);
    check("R2 pins all", {27'd0, fl_ce1, fl_wp, fl_ale, fl_cle, fl_ce0}, 32'h1F);
    fl_rdy = 1'b0;
    access(1'b0, 1'b0, 6'h18, 8'h00, q); check("R3 busy read", q, 32'hDF);
    fl_rdy = 1'b1;
    access(1'b0, 1'b0, 6'h18, 8'h00, q); check("R3 ready read", q, 32'hFF);
    access(1'b1, 1'b0, 6'h18, 8'h25, q);
    @(negedge clk);
    check("R2 pins 0x25", {27'd0, fl_ce1, fl_wp, fl_ale, fl_cle, fl_ce0}, 32'h05);
    fl_rdy = 1'b0;
    access(1'b0, 1'b0, 6'h18, 8'h00, q); check("R3 bit5 masked", q, 32'h05);
    access(1'b1, 1'b0, 6'h18, 8'h12, q);
    @(negedge clk);
    check("R2 pins 0x12", {27'd0, fl_ce1, fl_wp, fl_ale, fl_cle, fl_ce0}, 32'h12);
  endtask

  task automatic t_write_bytes();
    logic [31:0] q;
    int w0;
    w0 = wr_seen;
    access(1'b1, 1'b0, 6'h14, 8'hA5, q); model_digest(8'hA5);
    check("R4 one strobe", 32'(wr_seen - w0), 1);
    check("R4 byte out", 32'(wr_last), 32'hA5);
    access(1'b1, 1'b0, 6'h14, 8'h3D, q); model_digest(8'h3D);
    check("R4 second strobe", 32'(wr_seen - w0), 2);
    check("R4 byte out 2", 32'(wr_last), 32'h3D);
  endtask

  task automatic t_read_byte();
    logic [31:0] q;
    int r0;
    r0 = rd_seen;
    access(1'b0, 1'b0, 6'h14, 8'h00, q);
    check("R5 byte read", q, {24'h0, fmem[mptr]});
    check("R5 one strobe", 32'(rd_seen - r0), 1);
    model_digest(fmem[mptr]); mptr++;
  endtask

  task automatic t_read_wide();
    logic [31:0] q;
    int r0;
    r0 = rd_seen;
    access(1'b0, 1'b1, 6'h14, 8'h00, q);
    check("R6 wide read", q, {8'h0, fmem[mptr+1], 8'h0, fmem[mptr]});
    check("R6 two strobes", 32'(rd_seen - r0), 2);
    model_digest(fmem[mptr]); model_digest(fmem[mptr+1]); mptr += 2;
  endtask

  task automatic t_ecc_readback(input string tag);
    logic [31:0] q;
    access(1'b0, 1'b0, 6'h08, 8'h00, q); check({"R7 cpar ", tag}, q, {26'd0, e_cp});
    access(1'b0, 1'b0, 6'h0C, 8'h00, q); check({"R8 cnt ", tag}, q, 32'(e_cnt & 8'hFF));
    access(1'b0, 1'b0, 6'h00, 8'h00, q); check({"R9 lplo ", tag}, q, {24'd0, mix(e_la[3:0], e_lb[3:0])});
    access(1'b0, 1'b0, 6'h04, 8'h00, q); check({"R9 lphi ", tag}, q, {24'd0, mix(e_la[7:4], e_lb[7:4])});
  endtask

  task automatic t_clear();
    logic [31:0] q;
    access(1'b1, 1'b0, 6'h10, 8'h5A, q); model_clear();
    t_ecc_readback("after R10 clear");
    check("R10 cleared count", 32'(e_cnt), 0);
  endtask

  task automatic t_long_stream();
    logic [31:0] q;
    access(1'b1, 1'b0, 6'h10, 8'h00, q); model_clear();
    for (int i = 0; i < 300; i++) begin
      access(1'b1, 1'b0, 6'h14, 8'(i * 7 + 3), q);
      model_digest(8'(i * 7 + 3));
    end
    t_ecc_readback("stream300");
  endtask

  task automatic t_undefined();
    logic [31:0] q;
    int w0, r0;
    w0 = wr_seen; r0 = rd_seen;
    access(1'b0, 1'b0, 6'h1C, 8'h00, q); check("R11 read 0x1C", q, 0);
    access(1'b0, 1'b1, 6'h3C, 8'h00, q); check("R11 read 0x3C", q, 0);
    access(1'b0, 1'b0, 6'h10, 8'h00, q); check("R11 read clr reg", q, 0);
    access(1'b1, 1'b0, 6'h20, 8'h77, q);
    access(1'b1, 1'b0, 6'h0C, 8'h77, q);
    access(1'b1, 1'b0, 6'h08, 8'h77, q);
    check("R11 no strobes", 32'((wr_seen - w0) + (rd_seen - r0)), 0);
    access(1'b0, 1'b0, 6'h18, 8'h00, q); check("R11 ctl kept", q, 32'h12);
    t_ecc_readback("after R11 writes");
  endtask

  task automatic t_ack_width();
    check("R12 ack single cycle", 32'(ack_long), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) fmem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_control();
    t_write_bytes();
    t_read_byte();
    t_read_wide();
    t_read_wide();
    t_ecc_readback("mixed");
    t_clear();
    t_long_stream();
    t_undefined();
    t_ack_width();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule